// File: doc/BRIEF.md
# Converter Power-Sequencing Controller

This block is the digital power-management state machine of a successive-approximation converter core. It decides when the analog core is powered, when it is calibrating, when it is converting and when it is ready to accept a conversion. The analog conversion, the calibration arithmetic and the reference settling are not modelled. Each of them is a fixed busy interval whose length in clock cycles is set by a parameter. By default these parameters are derived from a clock-frequency parameter in kHz.

After reset the core is powered but not yet ready. The first falling edge of the active-low start strobe launches a combined timeout and self-calibration interval instead of a conversion. A configuration write that lands before that first strobe cancels the sequence. When power-down between conversions is selected, the core switches itself off in the cycle its busy flag drops. It wakes on the falling edge of the strobe and converts on the rising edge. A rising edge that comes while the core is still waking is held and then served. A software conversion request can also wake a sleeping core and then convert.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is applied and immediately after it is released, `pwr_en`=1, `ready`=0, `busy`=0 and `cal_active`=0.
- R2: In the post-reset state, a falling edge of `start_n` raises `cal_active` on the next cycle. `cal_active` then stays high for exactly CAL_CYCLES cycles while `busy` and `ready` stay low.
- R3: A one-cycle `cfg_wr` in the post-reset state with no `start_n` falling edge in that cycle makes `ready`=1 on the next cycle, and calibration never runs; a later `start_n` falling edge leaves `cal_active`=0. If `cfg_wr` and the first falling edge fall in the same cycle, calibration runs.
- R4: During calibration, `sleep_n`, `pm_mode`, `start_n`, `sw_conv` and `cfg_wr` have no effect on its length. The mode in force at its last cycle decides the outcome: normal mode gives `ready`=1, and any other mode gives `pwr_en`=0.
- R5: With `ready`=1 and `busy`=0, a rising edge of `start_n` (or a `sw_conv` pulse) raises `busy` on the next cycle for exactly CONV_CYCLES cycles.
- R6: Mode decode: `sleep_n`=0 selects power-down between conversions regardless of `pm_mode`. With `sleep_n`=1, `pm_mode`=2'b00 is normal (always powered), 2'b01 is power-down between conversions, and 2'b10 or 2'b11 is full software power-down.
- R7: In power-down-between-conversions mode, `pwr_en` and `ready` drop in the same cycle that `busy` drops.
- R8: While powered down in between-conversions mode, a falling edge of `start_n` raises `pwr_en` on the next cycle. `ready` stays low for exactly WAKE_CYCLES cycles and then rises.
- R9: A rising edge of `start_n` during the wake interval, including its final cycle, is held. `busy` and `ready` rise together in the first cycle after the wake interval.
- R10: A `sw_conv` pulse while powered down in between-conversions mode keeps `pwr_en` high for exactly WAKE_CYCLES+CONV_CYCLES cycles, with `busy` in the last CONV_CYCLES of them, and then powers down.
- R11: In full software power-down, a powered idle core turns off on the next cycle and stays off regardless of `start_n` and `sw_conv`. Changing to between-conversions mode keeps it off. Changing to normal mode starts a wake interval that ends with `ready`=1.
- R12: In normal mode, `pwr_en` stays high when a conversion finishes and `ready` remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_n | input | 1 | Active-low conversion-start strobe: falling edge wakes, rising edge converts |
| sleep_n | input | 1 | Low forces power-down between conversions |
| pm_mode | input | 2 | Power-management field (see R6) |
| cfg_wr | input | 1 | Configuration-register write strobe, one cycle |
| sw_conv | input | 1 | Software conversion request, one cycle |
| busy | output | 1 | Conversion in progress |
| pwr_en | output | 1 | Analog core power enable |
| cal_active | output | 1 | Power-up timeout and calibration in progress |
| ready | output | 1 | Core powered, calibrated and awake |

## Verification
Two coincidences matter here. The first is a held start request meeting the last cycle of the wake interval. The bench raises `start_n` so that its rising edge lands exactly on the final wake cycle. It then expects `busy` and `ready` to rise together on the next cycle, with exactly CONV_CYCLES busy cycles and no lost or duplicated conversion. The second is a configuration write that shares its cycle with the first falling strobe edge; here calibration must win, which the bench judges by `cal_active` going high rather than `ready`.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_CAL,
    ST_IDLE,
    ST_CONV,
    ST_DOWN,
    ST_WAKE
  } pwr_state_e;

  typedef enum logic [1:0] {
    PM_RUN,
    PM_CYCLE,
    PM_OFF
  } pwr_mode_e;

  // sleep pin low overrides the software field
  function automatic pwr_mode_e decode_mode(input logic sleep_n, input logic [1:0] pm);
    if (!sleep_n)  return PM_CYCLE;
    if (pm[1])     return PM_OFF;
    if (pm[0])     return PM_CYCLE;
    return PM_RUN;
  endfunction

endpackage

// File: rtl/adc_pwr_edge.sv
module adc_pwr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign fall = prev_q & ~strobe_n;
  assign rise = ~prev_q & strobe_n;
endmodule

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load | ~done;

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!done) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int CW          = 8,
  parameter int CAL_CYCLES  = 12,
  parameter int WAKE_CYCLES = 5,
  parameter int CONV_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fall,
  input  logic          rise,
  input  logic          cfg_wr,
  input  logic          sw_conv,
  input  pwr_mode_e     mode,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          busy,
  output logic          pwr_en,
  output logic          cal_active,
  output logic          ready
);
  localparam logic [CW-1:0] CAL_LD  = CW'(CAL_CYCLES - 1);
  localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_CYCLES - 1);
  localparam logic [CW-1:0] CONV_LD = CW'(CONV_CYCLES - 1);

  pwr_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       start_req;

  assign start_req = rise | sw_conv;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_INIT: begin
        if (fall) begin
          state_d  = ST_CAL;
          tmr_load = 1'b1;
          tmr_val  = CAL_LD;
        end else if (cfg_wr) begin
          state_d = ST_IDLE;
        end
      end
      ST_CAL: begin
        if (tmr_done) state_d = (mode == PM_RUN) ? ST_IDLE : ST_DOWN;
      end
      ST_IDLE: begin
        if (mode == PM_OFF) begin
          state_d = ST_DOWN;
        end else if (start_req) begin
          state_d  = ST_CONV;
          tmr_load = 1'b1;
          tmr_val  = CONV_LD;
        end
      end
      ST_CONV: begin
        if (tmr_done) state_d = (mode == PM_RUN) ? ST_IDLE : ST_DOWN;
      end
      ST_DOWN: begin
        pend_d = 1'b0;
        if ((mode == PM_RUN) || ((mode == PM_CYCLE) && (fall || sw_conv))) begin
          state_d  = ST_WAKE;
          tmr_load = 1'b1;
          tmr_val  = WAKE_LD;
          pend_d   = sw_conv;
        end
      end
      ST_WAKE: begin
        if (tmr_done) begin
          pend_d = 1'b0;
          if (pend_q || start_req) begin
            state_d  = ST_CONV;
            tmr_load = 1'b1;
            tmr_val  = CONV_LD;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (start_req) begin
          pend_d = 1'b1;
        end
      end
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign busy       = (state_q == ST_CONV);
  assign cal_active = (state_q == ST_CAL);
  assign pwr_en     = (state_q != ST_DOWN);
  assign ready      = (state_q == ST_IDLE) || (state_q == ST_CONV);

  // R4
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && !tmr_done) |=> cal_active);

  // R3
  cancel_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT && cfg_wr && !fall) |=> (ready && !cal_active));

  // R5
  start_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !busy && mode != PM_OFF && rise) |=> busy);

  // R7
  down_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr_done && mode != PM_RUN) |=> (!pwr_en && !busy && !ready));

  // R9
  pend_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && tmr_done && (pend_q || start_req)) |=> (busy && ready));

  // R11
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && mode == PM_OFF) |=> !pwr_en);
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int CLK_KHZ     = 6000,
  parameter int CAL_CYCLES  = CLK_KHZ * 35,
  parameter int WAKE_CYCLES = (CLK_KHZ * 5) / 1000,
  parameter int CONV_CYCLES = (CLK_KHZ * 13 + 3999) / 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_n,
  input  logic       sleep_n,
  input  logic [1:0] pm_mode,
  input  logic       cfg_wr,
  input  logic       sw_conv,
  output logic       busy,
  output logic       pwr_en,
  output logic       cal_active,
  output logic       ready
);
  localparam int MAX_A = (CAL_CYCLES > WAKE_CYCLES) ? CAL_CYCLES : WAKE_CYCLES;
  localparam int MAX_C = (MAX_A > CONV_CYCLES) ? MAX_A : CONV_CYCLES;
  localparam int CW    = $clog2(MAX_C + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          fall, rise;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  pwr_mode_e     mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign mode = decode_mode(sleep_n, pm_mode);

  adc_pwr_edge i_edge (
    .clk      (clk),
    .rst_n    (rst_ni),
    .strobe_n (start_n),
    .fall     (fall),
    .rise     (rise)
  );

  adc_pwr_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  adc_pwr_fsm #(
    .CW          (CW),
    .CAL_CYCLES  (CAL_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES),
    .CONV_CYCLES (CONV_CYCLES)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_ni),
    .fall       (fall),
    .rise       (rise),
    .cfg_wr     (cfg_wr),
    .sw_conv    (sw_conv),
    .mode       (mode),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .busy       (busy),
    .pwr_en     (pwr_en),
    .cal_active (cal_active),
    .ready      (ready)
  );
endmodule

// File: tb/test_adc_pwr_seq.sv
`timescale 1ns/1ps
module test_adc_pwr_seq;
  localparam int CAL  = 12;
  localparam int WAKE = 5;
  localparam int CONV = 4;

  logic clk = 1'b0;
  logic rst_n, start_n, sleep_n, cfg_wr, sw_conv;
  logic [1:0] pm_mode;
  logic busy, pwr_en, cal_active, ready;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_pwr_seq #(.CAL_CYCLES(CAL), .WAKE_CYCLES(WAKE), .CONV_CYCLES(CONV)) i_adc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .sleep_n(sleep_n), .pm_mode(pm_mode),
    .cfg_wr(cfg_wr), .sw_conv(sw_conv), .busy(busy), .pwr_en(pwr_en),
    .cal_active(cal_active), .ready(ready)
  );

  // {sleep_n, pm_mode, pwr_en one cycle after apply, pwr_en after conversion}
  localparam logic [4:0] VEC [8] = '{
    5'b1_00_1_1, 5'b1_01_1_0, 5'b1_10_0_0, 5'b1_11_0_0,
    5'b0_00_1_0, 5'b0_01_1_0, 5'b0_10_1_0, 5'b0_11_1_0
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_n = 1'b1; sleep_n = 1'b1; pm_mode = 2'b00;
    cfg_wr = 1'b0; sw_conv = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick();
  endtask

  task automatic go_idle();
    sleep_n = 1'b1; pm_mode = 2'b00;
    tick();
    if (!ready) repeat (WAKE) tick();
    chk("R11 ready after return to normal", ready, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pwr_en", pwr_en, 1'b1);
    chk("R1 ready", ready, 1'b0);
    chk("R1 busy", busy, 1'b0);
    chk("R1 cal_active", cal_active, 1'b0);

    // R2 / R4 first strobe launches calibration; junk inputs ignored
    start_n = 1'b0; tick();
    chk("R2 cal starts", cal_active, 1'b1);
    chk("R2 no ready in cal", ready, 1'b0);
    for (int i = 2; i <= CAL; i++) begin
      logic [3:0] iv;
      iv = 4'(i);
      sleep_n = iv[0]; pm_mode = iv[1:0]; start_n = iv[0];
      cfg_wr = 1'b1; sw_conv = 1'b1;
      tick();
      chk("R4 cal held", cal_active, 1'b1);
      chk("R2 busy low in cal", busy, 1'b0);
    end
    sleep_n = 1'b0; pm_mode = 2'b00; start_n = 1'b1; cfg_wr = 1'b0; sw_conv = 1'b0;
    tick();
    chk("R2 cal ends", cal_active, 1'b0);
    chk("R4 sleep applied after cal", pwr_en, 1'b0);

    // R8 wake then R5 conversion then R7 auto power-down
    start_n = 1'b0; tick();
    chk("R8 pwr up on fall", pwr_en, 1'b1);
    chk("R8 not ready", ready, 1'b0);
    repeat (WAKE - 1) begin tick(); chk("R8 still waking", ready, 1'b0); end
    tick();
    chk("R8 ready after wake", ready, 1'b1);
    start_n = 1'b1; tick();
    chk("R5 busy on rise", busy, 1'b1);
    repeat (CONV - 1) begin tick(); chk("R5 busy held", busy, 1'b1); end
    tick();
    chk("R5 busy ends", busy, 1'b0);
    chk("R7 pwr_en drops with busy", pwr_en, 1'b0);
    chk("R7 ready drops with busy", ready, 1'b0);

    // R9 early rise held pending
    start_n = 1'b0; tick(); tick();
    start_n = 1'b1; tick();
    chk("R9 no conv while waking", busy, 1'b0);
    repeat (WAKE - 3) begin tick(); chk("R9 pending wait", busy, 1'b0); end
    tick();
    chk("R9 busy at wake end", busy, 1'b1);
    chk("R9 ready at wake end", ready, 1'b1);
    repeat (CONV - 1) tick();
    tick();
    chk("R7 down after pending conv", pwr_en, 1'b0);

    // R9 rise on final wake cycle
    start_n = 1'b0; tick();
    repeat (WAKE - 1) begin tick(); chk("R9 waking", ready, 1'b0); end
    start_n = 1'b1; tick();
    chk("R9 rise on last wake cycle", busy, 1'b1);
    repeat (CONV - 1) begin tick(); chk("R9 single conv held", busy, 1'b1); end
    tick();
    chk("R9 single conv ends", busy, 1'b0);
    chk("R7 down after coincident conv", pwr_en, 1'b0);

    // R10 software start from power-down
    sw_conv = 1'b1; tick(); sw_conv = 1'b0;
    for (int i = 1; i <= WAKE + CONV; i++) begin
      chk("R10 powered", pwr_en, 1'b1);
      chk("R10 busy phase", busy, (i > WAKE) ? 1'b1 : 1'b0);
      tick();
    end
    chk("R10 down after sw conv", pwr_en, 1'b0);

    // R11 software full power-down
    sleep_n = 1'b1; pm_mode = 2'b10; tick();
    chk("R11 off", pwr_en, 1'b0);
    start_n = 1'b0; tick();
    chk("R11 fall ignored", pwr_en, 1'b0);
    start_n = 1'b1; tick();
    chk("R11 rise ignored", pwr_en, 1'b0);
    sw_conv = 1'b1; tick(); sw_conv = 1'b0;
    chk("R11 sw_conv ignored", pwr_en, 1'b0);
    pm_mode = 2'b01; tick();
    chk("R11 between keeps off", pwr_en, 1'b0);
    pm_mode = 2'b00; tick();
    chk("R11 normal wakes", pwr_en, 1'b1);
    chk("R11 waking not ready", ready, 1'b0);
    repeat (WAKE - 1) tick();
    tick();
    chk("R11 ready after wake", ready, 1'b1);

    // R6 / R12 / R7 mode table
    for (int v = 0; v < 8; v++) begin
      logic [4:0] e;
      e = VEC[v];
      go_idle();
      sleep_n = e[4]; pm_mode = e[3:2];
      tick();
      chk("R6 pwr after mode apply", pwr_en, e[1]);
      if (e[1]) begin
        start_n = 1'b0; tick();
        start_n = 1'b1; tick();
        chk("R5 table conv starts", busy, 1'b1);
        repeat (CONV - 1) tick();
        tick();
        chk("R6 busy done", busy, 1'b0);
        chk(e[0] ? "R12 stays powered" : "R7 powers down", pwr_en, e[0]);
      end
    end

    // R3 cancel by configuration write
    do_reset();
    cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    chk("R3 ready after cancel", ready, 1'b1);
    chk("R3 no cal", cal_active, 1'b0);
    start_n = 1'b0; tick();
    chk("R3 strobe fall no cal", cal_active, 1'b0);
    start_n = 1'b1; tick();
    chk("R3 rise converts", busy, 1'b1);
    repeat (CONV) tick();
    chk("R12 idle after conv", ready, 1'b1);

    // R3 coincidence: write and first strobe in same cycle
    do_reset();
    cfg_wr = 1'b1; start_n = 1'b0; tick(); cfg_wr = 1'b0;
    chk("R3 strobe wins", cal_active, 1'b1);
    chk("R3 not ready", ready, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule